// File: doc/BRIEF.md
# Masked Multi-Slot Target Address Matcher

This block decides whether an I2C target acknowledges the address byte that has just been shifted in. It holds four own-address slots, each with its own per-bit don't-care mask. An incoming byte is compared against all four slots at once. Each slot can also answer the general-call address. The block registers the acknowledge decision, a general-call flag, the index of the winning slot and a copy of the accepted byte. Software uses the copy to see which address was actually received.

Configuration goes through a small write/read port. One select bit chooses between the address bank and the mask bank, and the low select bits choose the slot. The surrounding bus engine handles start/stop detection, bit shifting, clock stretching and the data phase. It presents each complete address byte with a one-cycle strobe.

Top module: `addr_slot_matcher`

## Requirements
- R1: After a synchronous active-low reset, every address and mask register reads 0x00, and `ack`, `gc_hit`, `hit_slot` and `held_byte` are all zero. With every register at 0x00, no received byte is acknowledged.
- R2: `cfg_sel[2]` = 0 selects address register `cfg_sel[1:0]` and `cfg_sel[2]` = 1 selects mask register `cfg_sel[1:0]`. While `cfg_we` is high, the selected register takes `cfg_wdata` at the clock edge. `cfg_rdata` always shows the selected register without a clock delay.
- R3: Bit 0 of every mask register ignores writes and always reads back as 0.
- R4: An address register keeps its 7-bit own address in bits 7:1. A slot whose address field is nonzero matches when ((received XOR address) AND NOT mask) is zero over bits 7:1. Received bit 0 (the direction bit) never affects the match.
- R5: A slot whose address register holds 0x00 matches nothing, whatever its mask holds.
- R6: Bit 0 of an address register enables general call for that slot. The slot then matches a received byte whose bits 7:1 are all zero, whatever its mask holds, and `gc_hit` goes high.
- R7: `gc_hit` is high only when received bits 7:1 are zero and at least one slot has its general-call enable set. A zero byte that is accepted only through a masked own-address match sets `ack` but leaves `gc_hit` low.
- R8: When several slots match, `hit_slot` reports the lowest-numbered one.
- R9: `ack`, `gc_hit`, `hit_slot` and `held_byte` change only on the clock edge that samples `addr_stb` high. They take their new values one cycle after the strobe and keep them until the next strobe.
- R10: `held_byte` loads the whole received byte, bit 0 included, only when the decision is an acknowledge. A rejected byte leaves it unchanged.
- R11: `hit_slot` is 0 whenever `ack` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Bit 2: 0 = address bank, 1 = mask bank; bits 1:0: slot |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register contents |
| addr_byte | input | 8 | Received address byte (bit 0 = direction) |
| addr_stb | input | 1 | One-cycle strobe marking `addr_byte` valid |
| ack | output | 1 | Acknowledge decision for the last strobed byte |
| gc_hit | output | 1 | Last strobed byte was an accepted general call |
| hit_slot | output | 2 | Lowest matching slot index |
| held_byte | output | 8 | Last acknowledged address byte |

## Verification
The hardest case to reach from the ports is an overlap: several slots accept the same byte, through different routes. Examples are a masked own-address match in one slot and a general call in a lower one, or a masked match of the zero address with no general-call enable anywhere. Uniformly random bytes almost never hit a programmed address under a partial mask. For that reason the random stimulus draws addresses from a small pool and builds most received bytes from a chosen slot's address, flipping bits under its mask. Directed steps then set up the priority and general-call overlaps explicitly.

// File: rtl/addr_match_pkg.sv
// Shared types for the masked multi-slot address matcher.
package addr_match_pkg;

    // Per-slot comparison result: own-address route and general-call route.
    typedef struct packed {
        logic own_hit;
        logic gc_hit;
    } slot_hit_t;

endpackage

// File: rtl/amr_regfile.sv
// Configuration storage: one address register and one mask register per slot.
// Assumes a single write port; reads are combinational from the selected bank.
// Mask bit 0 is not stored and reads back as 0.
module amr_regfile #(
    parameter int NUM_SLOTS = 4,
    parameter int BYTE_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic                               cfg_is_mask,
    input  logic [IDX_W-1:0]                   cfg_idx,
    input  logic [BYTE_W-1:0]                  cfg_wdata,
    output logic [BYTE_W-1:0]                  cfg_rdata,
    output logic [NUM_SLOTS-1:0][BYTE_W-1:0]   adr_q,
    output logic [NUM_SLOTS-1:0][BYTE_W-1:0]   msk_q
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Address register of slot s: full byte, bit 0 is the general-call enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                adr_q[s] <= '0;
            end else if (cfg_we && !cfg_is_mask && (cfg_idx == IDX_W'(s))) begin
                adr_q[s] <= cfg_wdata;
            end
        end

        // Mask register of slot s: bits above 0 only, bit 0 held at zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msk_q[s] <= '0;
            end else if (cfg_we && cfg_is_mask && (cfg_idx == IDX_W'(s))) begin
                msk_q[s] <= {cfg_wdata[BYTE_W-1:1], 1'b0};
            end
        end
    end

    // Read mux over the selected bank and slot.
    always_comb begin
        cfg_rdata = cfg_is_mask ? msk_q[cfg_idx] : adr_q[cfg_idx];
    end

endmodule

// File: rtl/amr_slot_cmp.sv
// Compares one received address byte against one slot.
// Assumes bit 0 of the byte is the direction bit and is never compared.
// Own-address route is active only for a nonzero address field; the
// general-call route ignores the mask.
module amr_slot_cmp
    import addr_match_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] adr_cfg,
    input  logic [BYTE_W-1:0] msk_cfg,
    input  logic [BYTE_W-1:0] rx_byte,
    output slot_hit_t         hit
);

    localparam int FIELD_W = BYTE_W - 1;

    logic [FIELD_W-1:0] rx_field;
    logic [FIELD_W-1:0] own_field;
    logic [FIELD_W-1:0] care_diff;

    // Masked difference between received and own address fields.
    always_comb begin
        rx_field    = rx_byte[BYTE_W-1:1];
        own_field   = adr_cfg[BYTE_W-1:1];
        care_diff   = (rx_field ^ own_field) & ~msk_cfg[BYTE_W-1:1];
        hit.own_hit = (|own_field) && (care_diff == '0);
        hit.gc_hit  = adr_cfg[0] && (rx_field == '0);
    end

endmodule

// File: rtl/amr_resolve.sv
// Merges per-slot results into one decision and registers it on the strobe.
// Assumes at most one strobe per cycle; outputs hold between strobes.
module amr_resolve
    import addr_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int BYTE_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        stb,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  slot_hit_t [NUM_SLOTS-1:0]   hits,
    output logic                        ack_q,
    output logic                        gc_q,
    output logic [IDX_W-1:0]            idx_q,
    output logic [BYTE_W-1:0]           held_q
);

    logic             ack_d;
    logic             gc_d;
    logic [IDX_W-1:0] idx_d;

    // Lowest-index priority search and OR of both match routes.
    always_comb begin
        ack_d = 1'b0;
        gc_d  = 1'b0;
        idx_d = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hits[i].own_hit || hits[i].gc_hit) begin
                idx_d = IDX_W'(i);
                ack_d = 1'b1;
            end
            if (hits[i].gc_hit) begin
                gc_d = 1'b1;
            end
        end
    end

    // Decision registers, updated only when a byte is strobed in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            gc_q  <= 1'b0;
            idx_q <= '0;
        end else if (stb) begin
            ack_q <= ack_d;
            gc_q  <= gc_d;
            idx_q <= idx_d;
        end
    end

    // Copy of the last accepted byte, direction bit included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (stb && ack_d) begin
            held_q <= rx_byte;
        end
    end

endmodule

// File: rtl/addr_slot_matcher.sv
// Top of the masked multi-slot target address matcher.
// Assumes the address byte arrives fully shifted in with a one-cycle strobe;
// decision outputs are valid one clock after that strobe.
module addr_slot_matcher
    import addr_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int SEL_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              addr_stb,
    output logic              ack,
    output logic              gc_hit,
    output logic [IDX_W-1:0]  hit_slot,
    output logic [BYTE_W-1:0] held_byte
);

    logic [NUM_SLOTS-1:0][BYTE_W-1:0] adr_q;
    logic [NUM_SLOTS-1:0][BYTE_W-1:0] msk_q;
    slot_hit_t [NUM_SLOTS-1:0]        hits;

    amr_regfile #(
        .NUM_SLOTS (NUM_SLOTS),
        .BYTE_W    (BYTE_W),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_is_mask (cfg_sel[SEL_W-1]),
        .cfg_idx     (cfg_sel[IDX_W-1:0]),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .adr_q       (adr_q),
        .msk_q       (msk_q)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        amr_slot_cmp #(
            .BYTE_W (BYTE_W)
        ) u_cmp (
            .adr_cfg (adr_q[s]),
            .msk_cfg (msk_q[s]),
            .rx_byte (addr_byte),
            .hit     (hits[s])
        );
    end

    amr_resolve #(
        .NUM_SLOTS (NUM_SLOTS),
        .BYTE_W    (BYTE_W),
        .IDX_W     (IDX_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (addr_stb),
        .rx_byte (addr_byte),
        .hits    (hits),
        .ack_q   (ack),
        .gc_q    (gc_hit),
        .idx_q   (hit_slot),
        .held_q  (held_byte)
    );

endmodule

// File: rtl/amr_chk.sv
// Port-level properties of the address matcher, attached by bind.
module amr_chk #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 2,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [BYTE_W-1:0] cfg_rdata,
    input logic [BYTE_W-1:0] addr_byte,
    input logic              addr_stb,
    input logic              ack,
    input logic              gc_hit,
    input logic [IDX_W-1:0]  hit_slot,
    input logic [BYTE_W-1:0] held_byte
);

    // R3
    mask_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel[SEL_W-1] |-> (cfg_rdata[0] == 1'b0));

    // R6
    gc_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_hit |-> ack);

    // R11
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (hit_slot == '0));

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> $stable({ack, gc_hit, hit_slot, held_byte}));

    // R10
    reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> (ack || $stable(held_byte)));

    // R10
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> (!ack || (held_byte == $past(addr_byte))));

endmodule

bind addr_slot_matcher amr_chk #(
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata),
    .addr_byte (addr_byte),
    .addr_stb  (addr_stb),
    .ack       (ack),
    .gc_hit    (gc_hit),
    .hit_slot  (hit_slot),
    .held_byte (held_byte)
);

// File: tb/sim_addr_slot_matcher.sv
module sim_addr_slot_matcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] addr_byte = '0;
    logic       addr_stb = 1'b0;
    logic       ack;
    logic       gc_hit;
    logic [1:0] hit_slot;
    logic [7:0] held_byte;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_adr [4];
    logic [7:0] m_msk [4];
    logic [7:0] m_held;

    always #2.5 clk = ~clk;

    addr_slot_matcher u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .addr_byte (addr_byte),
        .addr_stb  (addr_stb),
        .ack       (ack),
        .gc_hit    (gc_hit),
        .hit_slot  (hit_slot),
        .held_byte (held_byte)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Expected decision from the requirements (R4..R8).
    function automatic void predict(input logic [7:0] rx, output logic e_ack,
                                    output logic e_gc, output logic [1:0] e_idx);
        e_ack = 1'b0;
        e_gc  = 1'b0;
        e_idx = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            logic own, gcm;
            own = (m_adr[i][7:1] != 7'd0) &&
                  ((((rx[7:1] ^ m_adr[i][7:1]) & ~m_msk[i][7:1])) == 7'd0);
            gcm = m_adr[i][0] && (rx[7:1] == 7'd0);
            if (own || gcm) begin
                e_ack = 1'b1;
                e_idx = 2'(i);
            end
            if (gcm) e_gc = 1'b1;
        end
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel[2]) m_msk[sel[1:0]] = {d[7:1], 1'b0};
        else        m_adr[sel[1:0]] = d;
    endtask

    task automatic rd(input string req, input logic [2:0] sel, input logic [7:0] exp);
        cfg_sel = sel;
        #1;
        chk(req, "cfg_rdata", cfg_rdata, exp);
    endtask

    task automatic probe(input string req, input logic [7:0] rx);
        logic e_ack, e_gc;
        logic [1:0] e_idx;
        predict(rx, e_ack, e_gc, e_idx);
        if (e_ack) m_held = rx;
        @(negedge clk);
        addr_byte = rx; addr_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
        addr_byte = ~rx;
        chk(req, "ack", {7'd0, ack}, {7'd0, e_ack});
        chk(req, "gc_hit", {7'd0, gc_hit}, {7'd0, e_gc});
        chk(req, "hit_slot", {6'd0, hit_slot}, {6'd0, e_idx});
        chk(req, "held_byte", held_byte, m_held);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) begin m_adr[i] = '0; m_msk[i] = '0; end
        m_held = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "ack", {7'd0, ack}, 8'd0);
        chk("R1", "held_byte", held_byte, 8'd0);
        for (int i = 0; i < 8; i++) rd("R1", 3'(i), 8'd0);
        probe("R1", 8'h00);
        probe("R1", 8'hA4);

        // R2: readback, R3: mask bit 0 ignored
        wr(3'd1, 8'hA5);
        rd("R2", 3'd1, 8'hA5);
        rd("R2", 3'd0, 8'h00);
        wr(3'd5, 8'hFF);
        rd("R3", 3'd5, 8'hFE);
        wr(3'd5, 8'h00);

        // R4: own match, direction bit ignored and kept (R10)
        wr(3'd2, 8'h50);
        probe("R4", 8'h51);
        chk("R10", "held bit0", held_byte, 8'h51);
        probe("R4", 8'h52);
        wr(3'd6, 8'h06);
        probe("R4", 8'h56);
        // R10: rejected byte leaves held copy
        probe("R10", 8'h90);
        chk("R10", "held kept", held_byte, 8'h57 & 8'h00 | m_held);
        // R9: hold after strobe
        @(negedge clk);
        chk("R9", "ack hold", {7'd0, ack}, 8'd0);

        // R5: zero register with full mask matches nothing
        wr(3'd7, 8'hFE);
        probe("R5", 8'h3C);

        // R8: priority, slots 1 and 2 both match
        wr(3'd1, 8'h50);
        probe("R8", 8'h50);
        chk("R8", "slot", {6'd0, hit_slot}, 8'd1);

        // R6: general call on slot 3 regardless of mask
        wr(3'd3, 8'h01);
        wr(3'd7, 8'hFE);
        probe("R6", 8'h01);
        chk("R6", "gc", {7'd0, gc_hit}, 8'd1);

        // R7: masked zero match without gc enable
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFE);
        wr(3'd0, 8'h10);
        probe("R7", 8'h00);
        chk("R7", "gc low", {7'd0, gc_hit}, 8'd0);
        chk("R11", "slot", {6'd0, hit_slot}, 8'd0);
        // R11: no ack gives slot 0
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        probe("R11", 8'h50);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] pool [8] = '{8'h00, 8'h01, 8'h20, 8'h21, 8'hA4, 8'hA5, 8'h7E, 8'h3B};
            logic [7:0] rx;
            int s;
            if (($urandom % 4) == 0) begin
                if ($urandom % 2) wr({1'b0, 2'($urandom)}, pool[$urandom % 8]);
                else              wr({1'b1, 2'($urandom)}, 8'($urandom) & 8'h1E);
            end
            s = $urandom % 4;
            case ($urandom % 4)
                0:       rx = 8'($urandom % 2);
                1:       rx = 8'($urandom);
                default: rx = m_adr[s] ^ (8'($urandom) & (m_msk[s] | 8'h01));
            endcase
            probe("R4", rx);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule